// File: doc/BRIEF.md
# Operand-Conditioning Integer ALU

This block is the purely combinational arithmetic unit of a small 32-bit integer core. It takes two operands, a 3-bit operation code and a shift qualifier. It returns a result word, a zero flag and a branch-taken bit. Subtraction and magnitude compares have no opcodes of their own. The decoder instead sets two conditioning controls that act on operand B before any function sees it: a bitwise inversion and an increment. Setting both turns the add operation into A minus B.

Branches reuse the same datapath. An equality branch runs a subtraction and tests the zero flag. An ordering branch runs a set-less-than and tests the zero flag of its 0/1 result. A separate invert-zero input flips the flag into the taken bit, so each branch condition and its complement share one computation.

The block has no clock, no reset and no flow control. Operands arrive and results leave in the same evaluation, so the interface carries no valid/ready pair.

Top module: `opcond_alu`

## Requirements
- R1: With op 000 (add), `result_o` equals `a_i` plus the conditioned operand B, modulo 2^32.
- R2: With op 000 and both `b_invert_i` and `b_inc_i` high, `result_o` equals `a_i` minus `b_i`, modulo 2^32.
- R3: The conditioned B is `b_i` bitwise inverted when `b_invert_i` is high, plus one when `b_inc_i` is high; each control acts alone when the other is low.
- R4: With op 001, `result_o` is `a_i` shifted left, filling with zeros, by the low 5 bits of the conditioned B; upper bits of B are ignored.
- R5: With op 101, `result_o` is `a_i` shifted right by the low 5 bits of the conditioned B, filling with bit 31 of `a_i` when `arith_i` is high and with zeros when it is low.
- R6: With op 010, `result_o` is 1 if `a_i` is less than the conditioned B as signed two's-complement values, else 0; bits 31..1 are always zero.
- R7: With op 011, `result_o` is 1 if `a_i` is less than the conditioned B as unsigned values, else 0; bits 31..1 are always zero.
- R8: Ops 100, 110 and 111 give the bitwise XOR, OR and AND of `a_i` and the conditioned B.
- R9: `zero_o` is high exactly when all 32 bits of `result_o` are zero.
- R10: `take_o` equals `zero_o` when `zero_invert_i` is low and its complement when `zero_invert_i` is high. Equal and not-equal branches use the subtract with invert-zero low and high. Less-than branches use op 010 or 011 with invert-zero high. Greater-or-equal branches use the same ops with invert-zero low.
- R11: `arith_i` has no effect on `result_o` for any op other than 101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B before conditioning |
| op_i | input | 3 | Operation code (000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 shift right, 110 or, 111 and) |
| arith_i | input | 1 | Selects the sign-filling right shift under op 101 |
| b_invert_i | input | 1 | Bitwise-invert operand B |
| b_inc_i | input | 1 | Add one to the (possibly inverted) operand B |
| zero_invert_i | input | 1 | Invert the zero flag to form the taken bit |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result is zero |
| take_o | output | 1 | Branch-taken decision |

## Verification
The arithmetic or compare result and the branch decision derived from it are produced together from a single operand pair. A fault in either one can hide behind the other. The bench drives subtracts and both less-than ops with the invert-zero input low and high, over operand pairs that are equal, ordered and reversed. Those pairs include 0x80000000 against 1, where signed and unsigned ordering disagree. Each application is judged on the result word, the zero flag and the taken bit separately, against a reference model written from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned ALU_W   = 32;
  localparam int unsigned OPSEL_W = 3;

  typedef enum logic [OPSEL_W-1:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SHR  = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu_b_cond.sv
// Operand B preconditioning: optional inversion then optional increment.
module alu_b_cond #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         invert_i,
  input  logic         inc_i,
  output logic [W-1:0] b_o
);

  logic [W-1:0] b_flip;

  assign b_flip = b_i ^ {W{invert_i}};
  assign b_o    = b_flip + W'(inc_i);

endmodule

// File: rtl/alu_shifter.sv
// Logarithmic barrel shifter producing a left and a right shift in parallel.
module alu_shifter #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHAMT_W = $clog2(W)
) (
  input  logic [W-1:0]       a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               arith_i,
  output logic [W-1:0]       left_o,
  output logic [W-1:0]       right_o
);

  logic           fill;
  logic [W-1:0]   lstage [SHAMT_W+1];
  logic [W-1:0]   rstage [SHAMT_W+1];

  assign fill      = arith_i & a_i[W-1];
  assign lstage[0] = a_i;
  assign rstage[0] = a_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign lstage[k+1] = amt_i[k] ? {lstage[k][W-1-STEP:0], {STEP{1'b0}}}
                                  : lstage[k];
    assign rstage[k+1] = amt_i[k] ? {{STEP{fill}}, rstage[k][W-1:STEP]}
                                  : rstage[k];
  end

  assign left_o  = lstage[SHAMT_W];
  assign right_o = rstage[SHAMT_W];

endmodule

// File: rtl/alu_compare.sv
// Signed and unsigned less-than from one shared borrow subtraction.
module alu_compare #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_signed_o,
  output logic         lt_unsigned_o
);

  logic [W:0] diff;
  logic       sign_mismatch;

  assign diff          = {1'b0, a_i} - {1'b0, b_i};
  assign sign_mismatch = a_i[W-1] ^ b_i[W-1];

  assign lt_unsigned_o = diff[W];
  assign lt_signed_o   = sign_mismatch ? a_i[W-1] : diff[W-1];

endmodule

// File: rtl/opcond_alu.sv
module opcond_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  logic [OPSEL_W-1:0] op_i,
  input  logic               arith_i,
  input  logic               b_invert_i,
  input  logic               b_inc_i,
  input  logic               zero_invert_i,
  output logic [W-1:0]       result_o,
  output logic               zero_o,
  output logic               take_o
);

  localparam int unsigned SHAMT_W = $clog2(W);

  alu_op_e      op;
  logic [W-1:0] b_c;
  logic [W-1:0] sum;
  logic [W-1:0] shl;
  logic [W-1:0] shr;
  logic         lt_s;
  logic         lt_u;

  assign op = alu_op_e'(op_i);

  alu_b_cond #(.W(W)) u_bcond (
    .b_i      (b_i),
    .invert_i (b_invert_i),
    .inc_i    (b_inc_i),
    .b_o      (b_c)
  );

  assign sum = a_i + b_c;

  alu_shifter #(.W(W), .SHAMT_W(SHAMT_W)) u_shift (
    .a_i     (a_i),
    .amt_i   (b_c[SHAMT_W-1:0]),
    .arith_i (arith_i),
    .left_o  (shl),
    .right_o (shr)
  );

  alu_compare #(.W(W)) u_cmp (
    .a_i           (a_i),
    .b_i           (b_c),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  result_o = sum;
      OP_SLL:  result_o = shl;
      OP_SLT:  result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(W-1){1'b0}}, lt_u};
      OP_XOR:  result_o = a_i ^ b_c;
      OP_SHR:  result_o = shr;
      OP_OR:   result_o = a_i | b_c;
      OP_AND:  result_o = a_i & b_c;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign take_o = zero_o ^ zero_invert_i;

endmodule

// File: rtl/opcond_alu_checker.sv
module opcond_alu_checker
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input logic [W-1:0]       a_i,
  input logic [W-1:0]       b_i,
  input logic [OPSEL_W-1:0] op_i,
  input logic               arith_i,
  input logic               b_invert_i,
  input logic               b_inc_i,
  input logic               zero_invert_i,
  input logic [W-1:0]       result_o,
  input logic               zero_o,
  input logic               take_o
);

  localparam int unsigned SHAMT_W = $clog2(W);

  logic plain_b;
  logic same_ab;
  logic nonzero_amt;

  assign plain_b     = !b_invert_i && !b_inc_i;
  assign same_ab     = (a_i == b_i);
  assign nonzero_amt = (b_i[SHAMT_W-1:0] != '0);

  always_comb begin
    if (op_i == OP_ADD && b_invert_i && b_inc_i && same_ab)
      a_r2_sub_equal_zero: assert (zero_o)
        else $error("subtract of equal operands not zero");
    if (op_i == OP_SLL && plain_b && nonzero_amt)
      a_r4_sll_lsb_clear: assert (!result_o[0])
        else $error("left shift left bit 0 set");
    if (op_i == OP_SHR && !arith_i && plain_b && nonzero_amt)
      a_r5_srl_msb_clear: assert (!result_o[W-1])
        else $error("logical right shift left the top bit set");
    if (op_i == OP_SLT || op_i == OP_SLTU)
      a_r6_slt_boolean: assert (result_o[W-1:1] == '0)
        else $error("compare result wider than one bit");
    if (op_i == OP_XOR && plain_b && same_ab)
      a_r8_xor_self_zero: assert (result_o == '0)
        else $error("xor of equal operands not zero");
    if (op_i == OP_SLTU && plain_b && same_ab && !zero_invert_i)
      a_r10_bgeu_equal_taken: assert (take_o)
        else $error("greater-or-equal branch not taken on equal operands");
  end

endmodule

bind opcond_alu opcond_alu_checker #(.W(W)) i_chk (.*);

// File: tb/test_opcond_alu.sv
module test_opcond_alu;

  localparam int unsigned W      = 32;
  localparam int unsigned NRAND  = 300;
  localparam int unsigned WD_MAX = 100000;

  typedef struct packed {
    logic [2:0]  op;
    logic        ar;
    logic        inv;
    logic        inc;
    logic        zi;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        z;
    logic        tk;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 32'd5,         32'd7,         32'd12,        1'b0, 1'b0}, // R1
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF,  32'd1,         32'd0,         1'b1, 1'b1}, // R1 wrap, R9
    '{3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 32'd10,        32'd3,         32'd7,         1'b0, 1'b0}, // R2
    '{3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234,      32'h1234,      32'd0,         1'b1, 1'b1}, // R2 R10 beq taken
    '{3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1234,      32'h1234,      32'd0,         1'b1, 1'b0}, // R10 bne not taken
    '{3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 32'd5,         32'd0,         32'd4,         1'b0, 1'b0}, // R3 invert only
    '{3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 32'd5,         32'd7,         32'd13,        1'b0, 1'b0}, // R3 inc only
    '{3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1,         32'd31,        32'h80000000,  1'b0, 1'b0}, // R4 by 31
    '{3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 32'd3,         32'h25,        32'h60,        1'b0, 1'b0}, // R4 low bits only
    '{3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80000000,  32'd31,        32'd1,         1'b0, 1'b0}, // R5 logical
    '{3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80000000,  32'd31,        32'hFFFFFFFF,  1'b0, 1'b0}, // R5 arith
    '{3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 32'h40000000,  32'd4,         32'h04000000,  1'b0, 1'b0}, // R5 arith positive
    '{3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h80000000,  32'd1,         32'd1,         1'b0, 1'b1}, // R6 R10 blt taken
    '{3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 32'h80000000,  32'd1,         32'd0,         1'b1, 1'b0}, // R7 R10 bltu not taken
    '{3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 32'd7,         32'd7,         32'd0,         1'b1, 1'b1}, // R6 R10 bge equal
    '{3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 32'hF0F0F0F0,  32'hFF00FF00,  32'h0FF00FF0,  1'b0, 1'b0}, // R8 xor
    '{3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 32'hF0F0F0F0,  32'hFF00FF00,  32'hFFF0FFF0,  1'b0, 1'b0}, // R8 or
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 32'hF0F0F0F0,  32'hFF00FF00,  32'hF000F000,  1'b0, 1'b0}, // R8 and
    '{3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 32'd5,         32'd7,         32'd12,        1'b0, 1'b0}, // R11 add
    '{3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000,  32'h0F0F0F0F,  32'h0F0F0000,  1'b0, 1'b0}, // R11 and
    '{3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 32'd1,         32'h80000000,  32'd1,         1'b0, 1'b0}  // R7
  };

  logic         clk = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [2:0]   op_i = '0;
  logic         arith_i = 1'b0;
  logic         b_invert_i = 1'b0;
  logic         b_inc_i = 1'b0;
  logic         zero_invert_i = 1'b0;
  logic [W-1:0] result_o;
  logic         zero_o;
  logic         take_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  opcond_alu i_opcond_alu (
    .a_i           (a_i),
    .b_i           (b_i),
    .op_i          (op_i),
    .arith_i       (arith_i),
    .b_invert_i    (b_invert_i),
    .b_inc_i       (b_inc_i),
    .zero_invert_i (zero_invert_i),
    .result_o      (result_o),
    .zero_o        (zero_o),
    .take_o        (take_o)
  );

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic ar,
                                          input logic inv, input logic inc,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] bc;
    logic [4:0]  sh;
    bc = inv ? ~b : b;
    if (inc) bc = bc + 32'd1;
    sh = bc[4:0];
    case (op)
      3'b000: return a + bc;
      3'b001: return a << sh;
      3'b010: return ($signed(a) < $signed(bc)) ? 32'd1 : 32'd0;
      3'b011: return (a < bc) ? 32'd1 : 32'd0;
      3'b100: return a ^ bc;
      3'b101: return ar ? 32'($signed(a) >>> sh) : (a >> sh);
      3'b110: return a | bc;
      default: return a & bc;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op, input logic ar);
    if (ar && op != 3'b101) return "R11";
    case (op)
      3'b000: return "R1 R2 R3";
      3'b001: return "R4";
      3'b010: return "R6";
      3'b011: return "R7";
      3'b101: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic ar, input logic inv,
                       input logic inc, input logic zi,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op_i = op; arith_i = ar; b_invert_i = inv; b_inc_i = inc;
    zero_invert_i = zi; a_i = a; b_i = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_MAX) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb, er;
    logic [2:0]  rop;
    logic        rar, rinv, rinc, rzi, ez;

    // Idle state: all-zero inputs add to zero.
    @(negedge clk);
    chk("R1", "idle result", result_o, 32'd0);
    chk("R9", "idle zero", {31'd0, zero_o}, 32'd1);
    chk("R10", "idle take", {31'd0, take_o}, 32'd1);

    // Table of directed vectors.
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].ar, VECS[i].inv, VECS[i].inc, VECS[i].zi,
            VECS[i].a, VECS[i].b);
      chk(req_of(VECS[i].op, VECS[i].ar), $sformatf("vector %0d result", i),
          result_o, VECS[i].res);
      chk("R9", $sformatf("vector %0d zero", i), {31'd0, zero_o}, {31'd0, VECS[i].z});
      chk("R10", $sformatf("vector %0d take", i), {31'd0, take_o}, {31'd0, VECS[i].tk});
    end

    // Branch pairs on one compare: signed/unsigned disagreement, both inversions.
    for (int zi = 0; zi < 2; zi++) begin
      apply(3'b010, 1'b0, 1'b0, 1'b0, 1'(zi), 32'hFFFFFFFF, 32'd0);
      chk("R6", "slt -1 vs 0", result_o, 32'd1);
      chk("R10", "blt/bge -1 vs 0", {31'd0, take_o}, {31'd0, 1'(zi)});
      apply(3'b011, 1'b0, 1'b0, 1'b0, 1'(zi), 32'hFFFFFFFF, 32'd0);
      chk("R7", "sltu -1 vs 0", result_o, 32'd0);
      chk("R10", "bltu/bgeu -1 vs 0", {31'd0, take_o}, {31'd0, 1'(1 - zi)});
    end

    // Randomized operands against the reference model.
    for (int n = 0; n < NRAND; n++) begin
      rop  = 3'($urandom_range(0, 7));
      rar  = 1'($urandom_range(0, 1));
      rzi  = 1'($urandom_range(0, 1));
      ra   = $urandom;
      rb   = ($urandom_range(0, 7) == 0) ? ra : $urandom;
      if (rop == 3'b000 || rop == 3'b010 || rop == 3'b011) begin
        rinv = 1'($urandom_range(0, 1));
        rinc = 1'($urandom_range(0, 1));
      end else begin
        rinv = 1'b0;
        rinc = 1'b0;
      end
      apply(rop, rar, rinv, rinc, rzi, ra, rb);
      er = ref_alu(rop, rar, rinv, rinc, ra, rb);
      ez = (er == 32'd0);
      chk(req_of(rop, rar), $sformatf("random %0d op %b result", n, rop), result_o, er);
      chk("R9", $sformatf("random %0d zero", n), {31'd0, zero_o}, {31'd0, ez});
      chk("R10", $sformatf("random %0d take", n), {31'd0, take_o}, {31'd0, ez ^ rzi});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule